// File: doc/BRIEF.md
# Multi-mode encoder position counter

This block keeps a position count from two encoder inputs, A and B. A two-bit mode field in the control register selects how edges on those inputs move one shared counter. In quadrature mode, every edge on either input is a step. In pulse/direction mode, rising edges of A are steps and B gives the sense. In the two single-input modes, A alone counts up or counts down. A resolution bit selects whether those single-input modes count on rising edges of A only or on both edges.

Both inputs pass through a two-flop synchroniser before any edge is detected. Software reaches the block through a four-word register port with a write strobe and a combinational read. The words are the count, an upper limit (ceiling), an initial value (floor) and a control word. The count wraps between 0 and the ceiling. Turning counting on loads the floor value. A written count above the ceiling is refused. An impossible quadrature jump leaves the count alone and raises a sticky error flag.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the count is 0, the ceiling reads all ones, the floor reads 0, the control word reads 0 and the phase error flag is low.
- R2: Register addresses are 0 count, 1 ceiling, 2 floor and 3 control. The control fields are mode in bits 15:14, dual-edge in bit 11 and enable in bit 3. In quadrature mode (mode 0), with the pair written {A,B}, each step of the sequence 00, 01, 11, 10 (cyclic) adds one to the count, and each step of the reverse sequence subtracts one.
- R3: In quadrature mode with counting enabled, a change of both inputs at once (00 and 11, or 01 and 10) leaves the count unchanged and sets phase_err_o. The flag stays set until a write to the control register clears it.
- R4: In pulse/direction mode (mode 1), only a rising edge of A is a step. It counts up when B is high and down when B is low. A falling edge of A, or any change of B, leaves the count unchanged.
- R5: In up mode (mode 2), B is ignored. With dual-edge 0 only rising edges of A add one, and with dual-edge 1 both edges of A add one.
- R6: In down mode (mode 3), B is ignored. With dual-edge 0 only rising edges of A subtract one, and with dual-edge 1 both edges of A subtract one.
- R7: While the enable bit is 0, input edges do not change the count.
- R8: A control write that sets the enable bit while it was clear loads the count with the floor value.
- R9: A count write with a value no greater than the ceiling replaces the count. A larger value is rejected and the count keeps its old value.
- R10: A step up from a count equal to the ceiling gives 0. A step down from 0 gives the ceiling.
- R11: When a count write and a count step fall in the same cycle, the written value wins and the step is lost.
- R12: An input change shows up in the count after the third rising clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 count, 1 ceiling, 2 floor, 3 control |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Combinational read data of the addressed register |
| count_o | output | CNT_W | Current position count |
| phase_err_o | output | 1 | Sticky quadrature phase error flag |

## Verification
A software write to the count and a decoded input step can land on the same clock edge. Only one value can enter the counter register, so the write must win. The bench provokes this by changing A at a known time and counting the three synchroniser and edge-detect registers. It then raises the write strobe exactly in the cycle where the step would take effect. The count must then hold the written value, not the value one step away from it and not the stepped old value. A second clash is a rejected write (above the ceiling) arriving alongside an input change. The assertions check that a refused write leaves the count untouched.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_PDIR = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } enc_mode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CEIL  = 2'd1;
  localparam logic [1:0] ADDR_FLOOR = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;

  localparam int unsigned CTRL_W        = 16;
  localparam int unsigned CTRL_EN_BIT   = 3;
  localparam int unsigned CTRL_DUAL_BIT = 11;
  localparam int unsigned CTRL_MODE_LSB = 14;

  // Position of an {A,B} pair on the quadrature ring 00 -> 01 -> 11 -> 10.
  function automatic logic [1:0] ring_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [DEPTH-1:0] shift_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[DEPTH-2:0], din[i]};
    end
    assign cur[i]  = shift_q[DEPTH-2];
    assign prev[i] = shift_q[DEPTH-1];
  end
endmodule

// File: rtl/enc_decoder.sv
module enc_decoder
  import enc_pkg::*;
(
  input  enc_mode_e mode,
  input  logic      dual_edge,
  input  logic      cur_a,
  input  logic      cur_b,
  input  logic      prev_a,
  input  logic      prev_b,
  output logic      step_up,
  output logic      step_dn,
  output logic      jump_err
);
  logic       rise_a;
  logic       chg_a;
  logic [1:0] ring_diff;

  always_comb begin
    rise_a    = cur_a & ~prev_a;
    chg_a     = cur_a ^ prev_a;
    ring_diff = ring_pos(cur_a, cur_b) - ring_pos(prev_a, prev_b);
    step_up   = 1'b0;
    step_dn   = 1'b0;
    jump_err  = 1'b0;
    case (mode)
      MODE_QUAD: begin
        step_up  = (ring_diff == 2'd1);
        step_dn  = (ring_diff == 2'd3);
        jump_err = (ring_diff == 2'd2);
      end
      MODE_PDIR: begin
        step_up = rise_a & cur_b;
        step_dn = rise_a & ~cur_b;
      end
      MODE_UP:   step_up = dual_edge ? chg_a : rise_a;
      default:   step_dn = dual_edge ? chg_a : rise_a;
    endcase
  end
endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
  import enc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count_o,
  output logic             phase_err_o
);
  localparam int unsigned PAD_W = CNT_W - CTRL_W;

  function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] top);
    return (c >= top) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] wrap_dec(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] top);
    return (c == '0) ? top : c - 1'b1;
  endfunction

  logic [CNT_W-1:0]  cnt_q, cnt_d, ceil_q, floor_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              perr_q;
  logic [1:0]        pin_cur, pin_prev;

  // Named internal events
  logic      wr_cnt, wr_ceil, wr_floor, wr_ctrl;
  logic      cnt_en, dual_edge, arm_load, write_ok;
  logic      step_up, step_dn, jump_err, evt_up, evt_dn, evt_err;
  enc_mode_e mode;

  enc_sync #(.N(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({enc_b, enc_a}),
    .cur  (pin_cur),
    .prev (pin_prev)
  );

  assign mode      = enc_mode_e'(ctrl_q[CTRL_MODE_LSB +: 2]);
  assign dual_edge = ctrl_q[CTRL_DUAL_BIT];
  assign cnt_en    = ctrl_q[CTRL_EN_BIT];

  enc_decoder dec_i (
    .mode     (mode),
    .dual_edge(dual_edge),
    .cur_a    (pin_cur[0]),
    .cur_b    (pin_cur[1]),
    .prev_a   (pin_prev[0]),
    .prev_b   (pin_prev[1]),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .jump_err (jump_err)
  );

  assign wr_cnt   = reg_wr_en && (reg_addr == ADDR_COUNT);
  assign wr_ceil  = reg_wr_en && (reg_addr == ADDR_CEIL);
  assign wr_floor = reg_wr_en && (reg_addr == ADDR_FLOOR);
  assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign write_ok = (reg_wdata <= ceil_q);
  assign arm_load = wr_ctrl && reg_wdata[CTRL_EN_BIT] && !cnt_en;
  assign evt_up   = cnt_en && step_up;
  assign evt_dn   = cnt_en && step_dn;
  assign evt_err  = cnt_en && jump_err;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt) begin
      if (write_ok) cnt_d = reg_wdata;
    end else if (arm_load) begin
      cnt_d = floor_q;
    end else if (evt_up) begin
      cnt_d = wrap_inc(cnt_q, ceil_q);
    end else if (evt_dn) begin
      cnt_d = wrap_dec(cnt_q, ceil_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ceil_q  <= '1;
      floor_q <= '0;
      ctrl_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_ceil)  ceil_q  <= reg_wdata;
      if (wr_floor) floor_q <= reg_wdata;
      if (wr_ctrl)  ctrl_q  <= reg_wdata[CTRL_W-1:0];
      if (evt_err)      perr_q <= 1'b1;
      else if (wr_ctrl) perr_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_COUNT: reg_rdata = cnt_q;
      ADDR_CEIL:  reg_rdata = ceil_q;
      ADDR_FLOOR: reg_rdata = floor_q;
      default:    reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
    endcase
  end

  assign count_o     = cnt_q;
  assign phase_err_o = perr_q;

  // Assertions
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !reg_wr_en) |=> $stable(cnt_q));

  assert_reject_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && (reg_wdata > ceil_q)) |=> $stable(cnt_q));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && (reg_wdata <= ceil_q)) |=> (cnt_q == $past(reg_wdata)));

  assert_wrap_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && evt_up && (cnt_q >= ceil_q)) |=> (cnt_q == '0));

  assert_wrap_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && evt_dn && (cnt_q == '0)) |=> (cnt_q == $past(ceil_q)));

  assert_load_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_load |=> (cnt_q == $past(floor_q)));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !wr_ctrl) |=> perr_q);

  assert_err_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err && !reg_wr_en) |=> ($stable(cnt_q) && perr_q));

endmodule

// File: tb/enc_pos_counter_tb.sv
`timescale 1ns/1ps
module enc_pos_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] count_o;
  logic        phase_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] exp_cnt;

  always #2 clk = ~clk;

  enc_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count_o(count_o), .phase_err_o(phase_err_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
    reg_addr = 2'd0;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(count_o, 32'd0, "R1 count");
    rd_chk(2'd1, 32'hFFFF_FFFF, "R1 ceiling");
    rd_chk(2'd2, 32'd0, "R1 floor");
    rd_chk(2'd3, 32'd0, "R1 control");
    chk({31'd0, phase_err_o}, 32'd0, "R1 phase_err");

    // R2/R3 quadrature sweep over every from/to pair, ring index = {a, a^b}
    wr(2'd2, 32'd100);
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] pf, pt, d;
        wr(2'd3, 32'h0000);
        drive(f[1], f[0]);
        wr(2'd3, 32'h0008);
        chk(count_o, 32'd100, "R8 floor load on enable");
        drive(t[1], t[0]);
        pf = {f[1], f[1] ^ f[0]};
        pt = {t[1], t[1] ^ t[0]};
        d  = pt - pf;
        exp_cnt = (d == 2'd1) ? 32'd101 : (d == 2'd3) ? 32'd99 : 32'd100;
        chk(count_o, exp_cnt, "R2 quadrature step");
        chk({31'd0, phase_err_o}, {31'd0, (d == 2'd2)}, "R3 phase error flag");
      end
    end
    // last state is {1,1}; jump to {0,0}
    exp_cnt = count_o;
    drive(1'b0, 1'b0);
    chk({31'd0, phase_err_o}, 32'd1, "R3 flag set on jump");
    chk(count_o, exp_cnt, "R3 count held on jump");
    repeat (3) @(negedge clk);
    chk({31'd0, phase_err_o}, 32'd1, "R3 flag sticky");
    wr(2'd3, 32'h0008);
    chk({31'd0, phase_err_o}, 32'd0, "R3 flag cleared by control write");
    chk(count_o, exp_cnt, "R3 clear write does not load");

    // R12 latency: {0,0} -> {0,1} is one step up
    @(negedge clk);
    enc_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(count_o, exp_cnt, "R12 unchanged after two edges");
    @(negedge clk);
    chk(count_o, exp_cnt + 32'd1, "R12 changed after third edge");
    drive(1'b0, 1'b0);

    // R4 pulse/direction
    wr(2'd3, 32'h4008);
    wr(2'd0, 32'd50);
    exp_cnt = 32'd50;
    for (int b = 1; b >= 0; b--) begin
      drive(1'b0, b[0]);
      chk(count_o, exp_cnt, "R4 B change ignored");
      drive(1'b1, b[0]);
      exp_cnt = b[0] ? exp_cnt + 32'd1 : exp_cnt - 32'd1;
      chk(count_o, exp_cnt, "R4 rising A with direction");
      drive(1'b0, b[0]);
      chk(count_o, exp_cnt, "R4 falling A ignored");
    end
    drive(1'b0, 1'b0);

    // R5 up and R6 down, both resolutions
    for (int dn = 0; dn < 2; dn++) begin
      for (int dual = 0; dual < 2; dual++) begin
        logic [31:0] sgn;
        sgn = dn[0] ? 32'hFFFF_FFFF : 32'd1;
        wr(2'd3, (dn[0] ? 32'hC008 : 32'h8008) | (dual[0] ? 32'h0800 : 32'h0));
        wr(2'd0, 32'd50);
        exp_cnt = 32'd50;
        drive(1'b1, 1'b0);
        exp_cnt = exp_cnt + sgn;
        chk(count_o, exp_cnt, dn[0] ? "R6 rising A" : "R5 rising A");
        drive(1'b0, 1'b0);
        if (dual[0]) exp_cnt = exp_cnt + sgn;
        chk(count_o, exp_cnt, dn[0] ? "R6 falling A per resolution" : "R5 falling A per resolution");
        drive(1'b0, 1'b1);
        chk(count_o, exp_cnt, dn[0] ? "R6 B rise ignored" : "R5 B rise ignored");
        drive(1'b0, 1'b0);
        chk(count_o, exp_cnt, dn[0] ? "R6 B fall ignored" : "R5 B fall ignored");
      end
    end

    // R7 disabled
    wr(2'd3, 32'h8000);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    chk(count_o, exp_cnt, "R7 disabled holds count");

    // R8 enable loads floor
    wr(2'd2, 32'd777);
    wr(2'd3, 32'h8008);
    chk(count_o, 32'd777, "R8 enable loads floor");

    // R9 writes against ceiling
    wr(2'd1, 32'd5);
    wr(2'd0, 32'd3);
    chk(count_o, 32'd3, "R9 write below ceiling");
    wr(2'd0, 32'd6);
    chk(count_o, 32'd3, "R9 write above ceiling rejected");
    wr(2'd0, 32'd5);
    chk(count_o, 32'd5, "R9 write equal to ceiling");
    rd_chk(2'd0, 32'd5, "R9 count readback");

    // R10 wrap
    drive(1'b1, 1'b0);
    chk(count_o, 32'd0, "R10 up wraps to 0");
    drive(1'b0, 1'b0);
    wr(2'd3, 32'hC008);
    drive(1'b1, 1'b0);
    chk(count_o, 32'd5, "R10 down wraps to ceiling");
    drive(1'b0, 1'b0);

    // R11 write and step in the same cycle (down mode, count 5)
    @(negedge clk);
    enc_a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd2;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk(count_o, 32'd2, "R11 write beats step");
    repeat (3) @(negedge clk);
    chk(count_o, 32'd2, "R11 step not applied later");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule